// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller with Shadow Cache

This block fronts an array of one-time-programmable fuse words and keeps a volatile copy of every word in a shadow cache. The fuse array is a behavioural model inside the block. Each fuse bit starts at 0 and can only be blown to 1. After reset the controller copies the whole array into the cache. Only then does it accept work from the host.

The host drives a start pulse together with a command code, a bank index, a word index and write data. It waits for a one-cycle `done` pulse, then takes the result word and the error flag. Read and override work on the cache. Sense and program work on the array and take a configurable number of cycles. The cache and the array can therefore disagree on purpose: an override changes only the cache, and a program changes only the array unless reload-after-program is selected.

Geometry (word width, banks, words per bank) and the index port widths are parameters. The index ports may be wider than the geometry needs, so out-of-range requests can occur and are reported.

Top module: `otp_fusebox_ctrl`

## Requirements
- R1: While `rst` is high, `busy_o` is 1 and `done_o` and `err_o` are 0. After `rst` falls, `busy_o` stays 1 for exactly NUM_BANKS*WORDS_PER_BANK rising edges while every fuse word is copied into the cache, and then drops to 0.
- R2: Program (command code 2) ORs the write data into the addressed fuse word and returns the resulting word on `rdata_o`. Data bits at 0 leave their fuses unchanged, bits that are already blown stay 1, and no fuse bit ever returns to 0.
- R3: Sense (command code 1) returns the addressed word straight from the fuse array and leaves the cache unchanged.
- R4: Read (command code 0) returns the addressed cache word. `done_o` is high after the accepting edge and `busy_o` never rises.
- R5: Override (command code 3) writes the write data into the addressed cache word only, echoes it on `rdata_o`, completes like a read, and leaves the fuse array unchanged.
- R6: With RELOAD_ON_PROG = 0, a program leaves the cache word at its old value. With RELOAD_ON_PROG = 1, the cache word takes the new fuse value at completion.
- R7: Sense and program keep `busy_o` high for SENSE_CYC and PROG_CYC cycles respectively. `done_o` is high after rising edge SENSE_CYC+1 (or PROG_CYC+1), counting the accepting edge as edge 1.
- R8: A request with bank >= NUM_BANKS or word >= WORDS_PER_BANK completes after the accepting edge with `done_o` = 1, `err_o` = 1 and `rdata_o` = 0. It changes neither the cache nor the array. The word address is bank*WORDS_PER_BANK + word.
- R9: A start pulse while `busy_o` is 1 is ignored: it produces no extra `done_o` and no cache or array write.
- R10: Blown fuses survive a later reset. The startup copy restores the cache from the array, which discards earlier overrides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| cmd_i | input | 2 | 0 read, 1 sense, 2 program, 3 override |
| bank_i | input | BANK_IDX_W | Bank index |
| word_i | input | WORD_IDX_W | Word index within the bank |
| wdata_i | input | WORD_W | Program mask or override value |
| rdata_o | output | WORD_W | Result word, valid with `done_o` |
| busy_o | output | 1 | Startup copy or long command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Out-of-range request, valid with `done_o` |

## Verification
- **Short commands:** read, override and every rejected request finish one edge after acceptance.
- **Long commands:** sense and program finish SENSE_CYC+1 and PROG_CYC+1 edges after acceptance.
- **Startup copy:** it ends exactly NUM_BANKS*WORDS_PER_BANK edges after reset is released.
- **How sampling keeps to this:** the bench drives requests on falling edges and counts rising edges from the accepting one. It samples `done_o`, `rdata_o` and `err_o` on the falling edge that follows each rising edge, so every result is checked at the exact cycle it is due. Because the count is exact, an early or late pulse counts as a failure.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_SENSE = 2'd1,
        CMD_PROG  = 2'd2,
        CMD_OVR   = 2'd3
    } otp_cmd_e;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAIT = 2'd2
    } otp_state_e;

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_array_cmd(otp_cmd_e c);
        return (c == CMD_SENSE) || (c == CMD_PROG);
    endfunction

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 24,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic              blow_en,
    input  logic [AW-1:0]     blow_addr,
    input  logic [WORD_W-1:0] blow_mask
);
    // Non-volatile model: no reset, power-on state all unblown.
    logic [WORD_W-1:0] fuse_q [DEPTH] = '{default: '0};

    always_ff @(posedge clk) begin
        if (blow_en) begin
            fuse_q[blow_addr] <= fuse_q[blow_addr] | blow_mask;
        end
    end

    assign rdata = fuse_q[raddr];
endmodule

// File: rtl/otp_shadow_cache.sv
module otp_shadow_cache #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 24,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata
);
    logic [WORD_W-1:0] shadow_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            shadow_q[waddr] <= wdata;
        end
    end

    assign rdata = shadow_q[raddr];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int TOTAL     = 24,
    parameter int AW        = 5,
    parameter int SENSE_CYC = 4,
    parameter int PROG_CYC  = 6,
    parameter bit RELOAD    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  otp_cmd_e          cmd,
    input  logic              addr_ok,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [AW-1:0]     arr_raddr,
    input  logic [WORD_W-1:0] arr_rdata,
    output logic              arr_we,
    output logic [AW-1:0]     arr_waddr,
    output logic [WORD_W-1:0] arr_wmask,
    output logic [AW-1:0]     cache_raddr,
    input  logic [WORD_W-1:0] cache_rdata,
    output logic              cache_we,
    output logic [AW-1:0]     cache_waddr,
    output logic [WORD_W-1:0] cache_wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int MAXC = int'(max_of(SENSE_CYC, PROG_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        otp_cmd_e          cmd;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
    } req_t;

    otp_state_e        state_q;
    req_t              req_q;
    logic [CW-1:0]     cnt_q;
    logic [AW-1:0]     load_q;
    logic              finish;
    logic              accept;
    logic [WORD_W-1:0] merged;

    assign accept = (state_q == ST_IDLE) && start;
    assign finish = (state_q == ST_WAIT) && (cnt_q == '0);
    assign merged = arr_rdata | req_q.data;
    assign busy   = (state_q != ST_IDLE);

    always_comb begin
        arr_raddr   = (state_q == ST_LOAD) ? load_q : req_q.addr;
        cache_raddr = addr;
        arr_we      = finish && (req_q.cmd == CMD_PROG);
        arr_waddr   = req_q.addr;
        arr_wmask   = req_q.data;
        cache_we    = 1'b0;
        cache_waddr = req_q.addr;
        cache_wdata = merged;
        if (state_q == ST_LOAD) begin
            cache_we    = 1'b1;
            cache_waddr = load_q;
            cache_wdata = arr_rdata;
        end else if (accept && addr_ok && cmd == CMD_OVR) begin
            cache_we    = 1'b1;
            cache_waddr = addr;
            cache_wdata = wdata;
        end else if (RELOAD && finish && req_q.cmd == CMD_PROG) begin
            cache_we    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            load_q  <= '0;
            cnt_q   <= '0;
            req_q   <= '0;
            rdata   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_LOAD: begin
                    load_q <= load_q + 1'b1;
                    if (load_q == AW'(TOTAL - 1)) state_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (start) begin
                        if (!addr_ok) begin
                            done  <= 1'b1;
                            err   <= 1'b1;
                            rdata <= '0;
                        end else if (is_array_cmd(cmd)) begin
                            req_q   <= '{cmd: cmd, addr: addr, data: wdata};
                            cnt_q   <= (cmd == CMD_SENSE) ? CW'(SENSE_CYC - 1)
                                                          : CW'(PROG_CYC - 1);
                            state_q <= ST_WAIT;
                        end else begin
                            done  <= 1'b1;
                            rdata <= (cmd == CMD_READ) ? cache_rdata : wdata;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        rdata   <= (req_q.cmd == CMD_PROG) ? merged : arr_rdata;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/otp_fusebox_ctrl.sv
module otp_fusebox_ctrl
    import otp_pkg::*;
#(
    parameter int WORD_W         = 32,
    parameter int NUM_BANKS      = 3,
    parameter int WORDS_PER_BANK = 8,
    parameter int BANK_IDX_W     = 2,
    parameter int WORD_IDX_W     = 4,
    parameter int SENSE_CYC      = 4,
    parameter int PROG_CYC       = 6,
    parameter bit RELOAD_ON_PROG = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [1:0]            cmd_i,
    input  logic [BANK_IDX_W-1:0] bank_i,
    input  logic [WORD_IDX_W-1:0] word_i,
    input  logic [WORD_W-1:0]     wdata_i,
    output logic [WORD_W-1:0]     rdata_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int TOTAL = NUM_BANKS * WORDS_PER_BANK;
    localparam int AW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    logic              req_ok;
    logic [AW-1:0]     req_addr;
    logic [AW-1:0]     arr_raddr, arr_waddr, cache_raddr, cache_waddr;
    logic [WORD_W-1:0] arr_rdata, arr_wmask, cache_rdata, cache_wdata;
    logic              arr_we, cache_we;

    always_comb begin
        req_ok   = (32'(bank_i) < 32'(NUM_BANKS)) && (32'(word_i) < 32'(WORDS_PER_BANK));
        req_addr = '0;
        if (req_ok) req_addr = AW'(32'(bank_i) * 32'(WORDS_PER_BANK) + 32'(word_i));
    end

    otp_fuse_array #(.WORD_W(WORD_W), .DEPTH(TOTAL), .AW(AW)) u_array (
        .clk       (clk),
        .raddr     (arr_raddr),
        .rdata     (arr_rdata),
        .blow_en   (arr_we),
        .blow_addr (arr_waddr),
        .blow_mask (arr_wmask)
    );

    otp_shadow_cache #(.WORD_W(WORD_W), .DEPTH(TOTAL), .AW(AW)) u_cache (
        .clk   (clk),
        .raddr (cache_raddr),
        .rdata (cache_rdata),
        .we    (cache_we),
        .waddr (cache_waddr),
        .wdata (cache_wdata)
    );

    otp_seq #(
        .WORD_W(WORD_W), .TOTAL(TOTAL), .AW(AW),
        .SENSE_CYC(SENSE_CYC), .PROG_CYC(PROG_CYC), .RELOAD(RELOAD_ON_PROG)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start_i),
        .cmd         (otp_cmd_e'(cmd_i)),
        .addr_ok     (req_ok),
        .addr        (req_addr),
        .wdata       (wdata_i),
        .arr_raddr   (arr_raddr),
        .arr_rdata   (arr_rdata),
        .arr_we      (arr_we),
        .arr_waddr   (arr_waddr),
        .arr_wmask   (arr_wmask),
        .cache_raddr (cache_raddr),
        .cache_rdata (cache_rdata),
        .cache_we    (cache_we),
        .cache_waddr (cache_waddr),
        .cache_wdata (cache_wdata),
        .rdata       (rdata_o),
        .busy        (busy_o),
        .done        (done_o),
        .err         (err_o)
    );
endmodule

// File: rtl/otp_fusebox_chk.sv
module otp_fusebox_chk #(
    parameter int WORD_W = 32,
    parameter int AW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [1:0]        cmd_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              req_ok,
    input logic [AW-1:0]     arr_raddr,
    input logic [WORD_W-1:0] arr_rdata,
    input logic              arr_we
);
    // R1: the cycle after reset the startup copy is running
    assert_load_busy_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy_o && !done_o);

    // R2: a fuse word seen at a steady address never loses a blown bit
    assert_fuse_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $stable(arr_raddr) |-> (($past(arr_rdata) & ~arr_rdata) == '0));

    // R4: accepted read completes one edge later without busy
    assert_read_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && cmd_i == 2'd0 |=> done_o && !busy_o);

    // R5: accepted override never blows a fuse
    assert_override_no_blow_R5: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && cmd_i == 2'd3 |=> !arr_we && done_o);

    // R7: valid sense or program enters the busy wait
    assert_long_cmd_busy_R7: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && req_ok && (cmd_i == 2'd1 || cmd_i == 2'd2) |=> busy_o && !done_o);

    // R8: out-of-range request finishes at once with error
    assert_range_error_R8: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && !req_ok |=> done_o && err_o && !busy_o);

    // R8: error is only ever flagged with done
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);
endmodule

bind otp_fusebox_ctrl otp_fusebox_chk #(.WORD_W(WORD_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .cmd_i     (cmd_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .req_ok    (req_ok),
    .arr_raddr (arr_raddr),
    .arr_rdata (arr_rdata),
    .arr_we    (arr_we)
);

// File: tb/test_otp_fusebox_ctrl.sv
module test_otp_fusebox_ctrl;
    localparam int TOTAL = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_m = 1'b0, start_r = 1'b0;
    logic [1:0]  cmd = '0;
    logic [1:0]  bank = '0;
    logic [3:0]  word = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_m, rdata_r;
    logic        busy_m, busy_r, done_m, done_r, err_m, err_r;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    otp_fusebox_ctrl #(.RELOAD_ON_PROG(1'b0)) i_otp_fusebox_ctrl (
        .clk(clk), .rst(rst), .start_i(start_m), .cmd_i(cmd), .bank_i(bank),
        .word_i(word), .wdata_i(wdata), .rdata_o(rdata_m), .busy_o(busy_m),
        .done_o(done_m), .err_o(err_m));

    otp_fusebox_ctrl #(.RELOAD_ON_PROG(1'b1)) i_otp_fusebox_ctrl_rl (
        .clk(clk), .rst(rst), .start_i(start_r), .cmd_i(cmd), .bank_i(bank),
        .word_i(word), .wdata_i(wdata), .rdata_o(rdata_r), .busy_o(busy_r),
        .done_o(done_r), .err_o(err_r));

    task automatic summary_and_end();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  cmd;
        logic [1:0]  bank;
        logic [3:0]  word;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        eerr;
        logic [7:0]  lat;
        logic [7:0]  req;
    } vec_t;

    // Codes: 0 read, 1 sense, 2 program, 3 override. Latency counts the accepting edge.
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 4'd0, 32'h0,        32'h0,        1'b0, 8'd1, 8'd4}, // R4 blank read
        '{2'd1, 2'd0, 4'd0, 32'h0,        32'h0,        1'b0, 8'd5, 8'd3}, // R3 blank sense
        '{2'd2, 2'd1, 4'd2, 32'hA5A50000, 32'hA5A50000, 1'b0, 8'd7, 8'd2}, // R2 first blow
        '{2'd1, 2'd1, 4'd2, 32'h0,        32'hA5A50000, 1'b0, 8'd5, 8'd3}, // R3
        '{2'd0, 2'd1, 4'd2, 32'h0,        32'h0,        1'b0, 8'd1, 8'd6}, // R6 no reload
        '{2'd2, 2'd1, 4'd2, 32'h000000FF, 32'hA5A500FF, 1'b0, 8'd7, 8'd2}, // R2 OR
        '{2'd2, 2'd1, 4'd2, 32'h0,        32'hA5A500FF, 1'b0, 8'd7, 8'd2}, // R2 zero data
        '{2'd2, 2'd1, 4'd2, 32'hA5000001, 32'hA5A500FF, 1'b0, 8'd7, 8'd2}, // R2 already blown
        '{2'd3, 2'd2, 4'd7, 32'h12345678, 32'h12345678, 1'b0, 8'd1, 8'd5}, // R5
        '{2'd0, 2'd2, 4'd7, 32'h0,        32'h12345678, 1'b0, 8'd1, 8'd5}, // R5 cache holds it
        '{2'd1, 2'd2, 4'd7, 32'h0,        32'h0,        1'b0, 8'd5, 8'd5}, // R5 array untouched
        '{2'd0, 2'd3, 4'd0, 32'h0,        32'h0,        1'b1, 8'd1, 8'd8}, // R8 bank
        '{2'd1, 2'd0, 4'd8, 32'h0,        32'h0,        1'b1, 8'd1, 8'd8}, // R8 word
        '{2'd2, 2'd0, 4'd9, 32'h0000FFFF, 32'h0,        1'b1, 8'd1, 8'd8}, // R8 program
        '{2'd1, 2'd1, 4'd1, 32'h0,        32'h0,        1'b0, 8'd5, 8'd8}, // R8 no alias blow
        '{2'd3, 2'd2, 4'd8, 32'h0000DEAD, 32'h0,        1'b1, 8'd1, 8'd8}, // R8 override
        '{2'd0, 2'd2, 4'd0, 32'h0,        32'h0,        1'b0, 8'd1, 8'd8}  // R8 no alias write
    };

    task automatic run_cmd(input bit rl, input logic [1:0] c, input logic [1:0] b,
                           input logic [3:0] w, input logic [31:0] d,
                           input logic [31:0] exp, input logic eerr,
                           input int lat, input string req);
        int n;
        logic dn, er;
        logic [31:0] rd;
        @(negedge clk);
        cmd = c; bank = b; word = w; wdata = d;
        if (rl) start_r = 1'b1; else start_m = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start_m = 1'b0; start_r = 1'b0;
        dn = rl ? done_r : done_m;
        while (!dn && n < 64) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            dn = rl ? done_r : done_m;
        end
        rd = rl ? rdata_r : rdata_m;
        er = rl ? err_r : err_m;
        chk(n == lat, {req, " latency"}, 32'(n), 32'(lat));
        chk(rd == exp, {req, " data"}, rd, exp);
        chk(er == eerr, {req, " error flag"}, 32'(er), 32'(eerr));
    endtask

    task automatic reset_and_load(input string req);
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_m && !done_m && !err_m, req, {29'd0, busy_m, done_m, err_m}, 32'h4);
        rst = 1'b0;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (busy_m && n < 100);
        chk(n == TOTAL, {req, " load length"}, 32'(n), 32'(TOTAL));
    endtask

    initial begin
        int dones;
        // R1 reset state and startup copy length
        reset_and_load("R1");

        foreach (VECS[i]) begin
            run_cmd(1'b0, VECS[i].cmd, VECS[i].bank, VECS[i].word, VECS[i].wdata,
                    VECS[i].exp, VECS[i].eerr, int'(VECS[i].lat),
                    $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R9: override pulse during a sense is ignored
        @(negedge clk);
        cmd = 2'd1; bank = 2'd0; word = 4'd0; start_m = 1'b1;
        @(negedge clk);
        cmd = 2'd3; word = 4'd1; wdata = 32'h0000FFFF;
        @(negedge clk);
        start_m = 1'b0;
        dones = 0;
        repeat (10) begin
            @(posedge clk);
            @(negedge clk);
            if (done_m) dones++;
        end
        chk(dones == 1, "R9 done count", 32'(dones), 32'd1);
        run_cmd(1'b0, 2'd0, 2'd0, 4'd1, 32'h0, 32'h0, 1'b0, 1, "R9 cache unchanged");

        // R10: fuses persist, override lost after reset
        reset_and_load("R10");
        run_cmd(1'b0, 2'd0, 2'd1, 4'd2, 32'h0, 32'hA5A500FF, 1'b0, 1, "R10 cache reloaded");
        run_cmd(1'b0, 2'd0, 2'd2, 4'd7, 32'h0, 32'h0, 1'b0, 1, "R10 override dropped");

        // R6: reload-after-program variant
        run_cmd(1'b1, 2'd2, 2'd0, 4'd3, 32'h0000000F, 32'h0000000F, 1'b0, 7, "R6 reload prog");
        run_cmd(1'b1, 2'd0, 2'd0, 4'd3, 32'h0, 32'h0000000F, 1'b0, 1, "R6 reload read");
        run_cmd(1'b1, 2'd2, 2'd2, 4'd0, 32'h00F00000, 32'h00F00000, 1'b0, 7, "R7 program timing");
        run_cmd(1'b1, 2'd1, 2'd2, 4'd0, 32'h0, 32'h00F00000, 1'b0, 5, "R7 sense timing");

        summary_and_end();
    end
endmodule